// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This unit watches every bus access and decides which of eight programmable address regions, if any, owns it. Each region holds four things: a base address, an address mask, a valid flag and a control word. The unit drives one active-low select line for the owning region for the whole bus cycle.

The control word does several jobs. It sets a wait-state count and turns auto-acknowledge on or off. It carries five access-type block bits and a flag that exempts external masters from the code/data blocks. It also holds port-size and burst-enable fields, which are only stored and read back. With auto-acknowledge on, the unit counts the programmed waits and then raises an internal transfer acknowledge. An external acknowledge that arrives earlier ends the cycle at once.

Out of reset, channel 0 serves as a global select. It claims every address with fifteen wait states, so boot code can be fetched before software has programmed anything. Software programs regions through a small word-addressed register port, and bus masters present accesses through a start strobe with address, access type and an external-master flag.

Top module: `csu_top`

## Requirements
- R1: After reset every select reads high and the cycle-busy output is low. Channel 0's control word reads 0x0000003F (15 waits, auto-acknowledge on, external-master flag on). All other registers of every channel read zero.
- R2: Register address is {channel, sel}, with sel in the low two bits. sel=0 holds the base in data bits 31..16. sel=1 holds the mask in bits 31..16 and the valid flag in bit 0. sel=2 holds the control word in bits 14..0: wait count 3..0, auto-acknowledge 4, external-master flag 5, port size 7..6, burst read 8, burst write 9, block bits 14..10. sel=3 reads zero. Every other bit reads zero whatever was written.
- R3: A region matches when address bits 31..16 equal its base in every bit position where its mask bit is 0. Mask bits that are 1 are don't-care.
- R4: When several regions would select, the lowest-numbered channel wins. At most one select is ever low.
- R5: A channel whose valid flag is 0 never drives its select low, unless it is channel 0 in global mode (R6).
- R6: Channel 0 matches every address from reset until software first writes its valid flag to 1. From then on it decodes like any other region.
- R7: With auto-acknowledge on and wait count W, the internal acknowledge is high in cycle W of the bus cycle, counting the first cycle after the start strobe as cycle 0. The cycle ends after that cycle, and W=15 gives fifteen waits.
- R8: With auto-acknowledge off, the internal acknowledge never rises. The cycle ends only on the external acknowledge.
- R9: An external acknowledge ends the cycle after the cycle in which it is seen. The internal acknowledge is then suppressed, even while waits are still being counted.
- R10: Access types are encoded as 0 CPU-space/interrupt-acknowledge, 1 supervisor code, 2 supervisor data, 3 user code and 4 user data. Block bit 10+type set to 1 stops that type from selecting the region. Such an access runs as a plain cycle with no select and no internal acknowledge.
- R11: When a region's external-master flag is 0, its four code/data block bits are ignored for accesses marked as external master. The CPU-space block bit still applies.
- R12: The select is decided when the start strobe arrives and held unchanged until the cycle ends. It returns high when the cycle ends. A start strobe during a busy cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address {channel, sel} |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| cyc_start | input | 1 | Start strobe for a bus cycle |
| cyc_addr | input | 32 | Access address |
| cyc_space | input | 3 | Access type code |
| cyc_ext_master | input | 1 | Access comes from an external master or DMA |
| ext_ack | input | 1 | External transfer acknowledge |
| cs_n | output | 8 | Active-low selects, one per channel |
| int_ack | output | 1 | Internal transfer acknowledge |
| cyc_busy | output | 1 | A bus cycle is in progress |

## Verification
The bench builds the unit with its default parameters: eight channels, a four-bit wait field and a 16-bit compare on address bits 31..16. With eight channels, the bench can stack overlapping regions, an invalid region, a masked region and an external-master region side by side. The full four-bit wait field lets the boot select's fifteen-wait cycle run end to end. The 16-bit compare makes the don't-care mask visible at both byte boundaries of the upper address half.

// File: rtl/csu_pkg.sv
// Shared types for the chip-select unit.
// Assumes: access-type codes 0..4; other codes are never blocked.
package csu_pkg;

    localparam int WS_W    = 4;
    localparam int N_SPACE = 5;

    typedef enum logic [2:0] {
        SP_CPU      = 3'd0,
        SP_SUP_CODE = 3'd1,
        SP_SUP_DATA = 3'd2,
        SP_USR_CODE = 3'd3,
        SP_USR_DATA = 3'd4
    } space_e;

    typedef struct packed {
        logic [N_SPACE-1:0] space_block;
        logic               burst_wr;
        logic               burst_rd;
        logic [1:0]         port_size;
        logic               xm_honor;
        logic               auto_ack;
        logic [WS_W-1:0]    wait_cnt;
    } ctrl_t;

    localparam ctrl_t CTRL_BOOT = '{
        space_block: '0,
        burst_wr:    1'b0,
        burst_rd:    1'b0,
        port_size:   2'b00,
        xm_honor:    1'b1,
        auto_ack:    1'b1,
        wait_cnt:    '1
    };

endpackage

// File: rtl/csu_regfile.sv
// Register bank of the chip-select unit: base, mask, valid and control per
// channel, plus the one-way global-select flag of channel 0.
// Assumes: word address {channel, sel}; reads are combinational.
module csu_regfile
    import csu_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int DATA_W  = 32,
    parameter int CMP_LSB = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr,
    input  logic [$clog2(N_CH)+1:0]           addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 rdata,
    output logic [N_CH-1:0][DATA_W-CMP_LSB-1:0] base_o,
    output logic [N_CH-1:0][DATA_W-CMP_LSB-1:0] mask_o,
    output logic [N_CH-1:0]                   valid_o,
    output ctrl_t [N_CH-1:0]                  ctrl_o,
    output logic                              boot_o
);
    localparam int CH_W   = $clog2(N_CH);
    localparam int CMP_W  = DATA_W - CMP_LSB;
    localparam int CTRL_W = $bits(ctrl_t);

    logic [CH_W-1:0] sel_ch;
    logic [1:0]      sel_reg;

    assign sel_ch  = addr[CH_W+1:2];
    assign sel_reg = addr[1:0];

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        localparam ctrl_t CTRL_RST = (g == 0) ? CTRL_BOOT : '0;
        logic hit_me;
        assign hit_me = wr && (sel_ch == CH_W'(g));

        // Per-channel register update from the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_o[g]  <= '0;
                mask_o[g]  <= '0;
                valid_o[g] <= 1'b0;
                ctrl_o[g]  <= CTRL_RST;
            end else if (hit_me) begin
                case (sel_reg)
                    2'd0: base_o[g] <= wdata[CMP_LSB +: CMP_W];
                    2'd1: begin
                        mask_o[g]  <= wdata[CMP_LSB +: CMP_W];
                        valid_o[g] <= wdata[0];
                    end
                    2'd2: ctrl_o[g] <= ctrl_t'(wdata[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    // Global-select flag: cleared for good on the first valid write to channel 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            boot_o <= 1'b1;
        else if (wr && sel_ch == '0 && sel_reg == 2'd1 && wdata[0])
            boot_o <= 1'b0;
    end

    // Read multiplexer; unused bits return zero.
    always_comb begin
        rdata = '0;
        case (sel_reg)
            2'd0: rdata[CMP_LSB +: CMP_W] = base_o[sel_ch];
            2'd1: begin
                rdata[CMP_LSB +: CMP_W] = mask_o[sel_ch];
                rdata[0]                = valid_o[sel_ch];
            end
            2'd2: rdata[CTRL_W-1:0] = ctrl_o[sel_ch];
            default: ;
        endcase
    end

    AST_BOOT_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_o |=> !boot_o); // R6

endmodule

// File: rtl/csu_decode.sv
// Combinational region decode: address compare, valid gating, access-type
// blocking with the external-master exemption, and lowest-channel priority.
// Assumes: addr_hi holds the compared upper address bits only.
module csu_decode
    import csu_pkg::*;
#(
    parameter int N_CH  = 8,
    parameter int CMP_W = 16
) (
    input  logic [CMP_W-1:0]             addr_hi,
    input  logic [2:0]                   space,
    input  logic                         ext_master,
    input  logic [N_CH-1:0][CMP_W-1:0]   base,
    input  logic [N_CH-1:0][CMP_W-1:0]   mask,
    input  logic [N_CH-1:0]              valid,
    input  ctrl_t [N_CH-1:0]             ctrl,
    input  logic                         boot,
    output logic                         hit_any,
    output logic [N_CH-1:0]              hit_onehot,
    output logic [WS_W-1:0]              hit_ws,
    output logic                         hit_auto
);
    logic [N_CH-1:0] raw_hit;
    logic            space_legal;

    assign space_legal = (space < 3'(N_SPACE));

    for (genvar g = 0; g < N_CH; g++) begin : g_match
        logic addr_ok;
        logic live;
        logic blocked;

        // Address compare on unmasked bits; channel 0 also claims all in global mode.
        always_comb begin
            addr_ok = (((addr_hi ^ base[g]) & ~mask[g]) == '0);
            live    = valid[g];
            if (g == 0 && boot) begin
                addr_ok = 1'b1;
                live    = 1'b1;
            end
        end

        // Access-type block, with code/data blocks waived for exempt external masters.
        always_comb begin
            if (!space_legal)
                blocked = 1'b0;
            else if (space_e'(space) == SP_CPU)
                blocked = ctrl[g].space_block[0];
            else if (ext_master && !ctrl[g].xm_honor)
                blocked = 1'b0;
            else
                blocked = ctrl[g].space_block[space];
        end

        assign raw_hit[g] = addr_ok && live && !blocked;
    end

    // Priority pick: scanning downward leaves the lowest matching channel.
    always_comb begin
        hit_any    = 1'b0;
        hit_onehot = '0;
        hit_ws     = '0;
        hit_auto   = 1'b0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit_any    = 1'b1;
                hit_onehot = '0;
                hit_onehot[i] = 1'b1;
                hit_ws     = ctrl[i].wait_cnt;
                hit_auto   = ctrl[i].auto_ack;
            end
        end
    end

endmodule

// File: rtl/csu_wait_ack.sv
// Bus-cycle sequencer: latches the decode at the start strobe, holds the
// select, counts wait states and ends the cycle on internal or external ack.
// Assumes: start strobes seen while busy are dropped.
module csu_wait_ack
    import csu_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             hit_any,
    input  logic [N_CH-1:0]  hit_onehot,
    input  logic [WS_W-1:0]  hit_ws,
    input  logic             hit_auto,
    input  logic             ext_ack,
    output logic             busy_o,
    output logic [N_CH-1:0]  cs_act_o,
    output logic             int_ack_o
);
    logic [WS_W-1:0] cnt_q;
    logic            auto_q;
    logic            done;

    assign int_ack_o = busy_o && auto_q && (cnt_q == '0) && !ext_ack;
    assign done      = busy_o && (ext_ack || int_ack_o);

    // Cycle state: launch, count down, and release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o   <= 1'b0;
            cnt_q    <= '0;
            auto_q   <= 1'b0;
            cs_act_o <= '0;
        end else if (!busy_o && start) begin
            busy_o   <= 1'b1;
            cnt_q    <= hit_ws;
            auto_q   <= hit_any && hit_auto;
            cs_act_o <= hit_any ? hit_onehot : '0;
        end else if (done) begin
            busy_o   <= 1'b0;
            cs_act_o <= '0;
        end else if (busy_o && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_WAIT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !ext_ack && cnt_q != '0 |=> cnt_q == $past(cnt_q) - 1'b1); // R7

    AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |=> !busy_o); // R7

    AST_EXT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && ext_ack |=> !busy_o); // R9

    AST_ACK_NOT_WITH_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        int_ack_o |-> !ext_ack); // R9

endmodule

// File: rtl/csu_top.sv
// Chip-select and wait-state unit top: register bank, region decode and
// bus-cycle sequencer.
// Assumes: one bus cycle at a time; selects are registered.
module csu_top
    import csu_pkg::*;
#(
    parameter int N_CH    = 8,
    parameter int ADDR_W  = 32,
    parameter int CMP_LSB = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [$clog2(N_CH)+1:0]   reg_addr,
    input  logic [ADDR_W-1:0]         reg_wdata,
    output logic [ADDR_W-1:0]         reg_rdata,
    input  logic                      cyc_start,
    input  logic [ADDR_W-1:0]         cyc_addr,
    input  logic [2:0]                cyc_space,
    input  logic                      cyc_ext_master,
    input  logic                      ext_ack,
    output logic [N_CH-1:0]           cs_n,
    output logic                      int_ack,
    output logic                      cyc_busy
);
    localparam int CMP_W = ADDR_W - CMP_LSB;

    logic [N_CH-1:0][CMP_W-1:0] base;
    logic [N_CH-1:0][CMP_W-1:0] mask;
    logic [N_CH-1:0]            valid;
    ctrl_t [N_CH-1:0]           ctrl;
    logic                       boot;
    logic                       hit_any;
    logic [N_CH-1:0]            hit_onehot;
    logic [WS_W-1:0]            hit_ws;
    logic                       hit_auto;
    logic [N_CH-1:0]            cs_act;

    csu_regfile #(.N_CH(N_CH), .DATA_W(ADDR_W), .CMP_LSB(CMP_LSB)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata),
        .base_o(base), .mask_o(mask), .valid_o(valid), .ctrl_o(ctrl),
        .boot_o(boot)
    );

    csu_decode #(.N_CH(N_CH), .CMP_W(CMP_W)) u_dec (
        .addr_hi(cyc_addr[CMP_LSB +: CMP_W]), .space(cyc_space),
        .ext_master(cyc_ext_master), .base(base), .mask(mask),
        .valid(valid), .ctrl(ctrl), .boot(boot),
        .hit_any(hit_any), .hit_onehot(hit_onehot),
        .hit_ws(hit_ws), .hit_auto(hit_auto)
    );

    csu_wait_ack #(.N_CH(N_CH)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(cyc_start),
        .hit_any(hit_any), .hit_onehot(hit_onehot),
        .hit_ws(hit_ws), .hit_auto(hit_auto), .ext_ack(ext_ack),
        .busy_o(cyc_busy), .cs_act_o(cs_act), .int_ack_o(int_ack)
    );

    assign cs_n = ~cs_act;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R4

    AST_CS_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_busy |-> &cs_n); // R12

    AST_CS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy && $past(cyc_busy) |-> $stable(cs_n)); // R12

    for (genvar g = 0; g < N_CH; g++) begin : g_chk
        if (g == 0) begin : g_c0
            AST_CS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cs_n[g]) |-> $past(valid[g] || boot)); // R5
        end else begin : g_cn
            AST_CS_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(cs_n[g]) |-> $past(valid[g])); // R5
        end
    end

endmodule

// File: tb/tb_csu_top.sv
// Directed bench for the chip-select unit: one task per scenario.
module tb_csu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cyc_start = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic [2:0]  cyc_space = '0;
    logic        cyc_ext_master = 1'b0;
    logic        ext_ack = 1'b0;
    logic [7:0]  cs_n;
    logic        int_ack;
    logic        cyc_busy;

    int checks = 0;
    int failures = 0;
    logic [7:0] r_cs;
    logic [7:0] r_idle_cs;
    logic       r_cs_ok;
    int         r_ack;
    int         r_len;

    always #4 clk = ~clk;

    csu_top dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cyc_start(cyc_start),
        .cyc_addr(cyc_addr), .cyc_space(cyc_space),
        .cyc_ext_master(cyc_ext_master), .ext_ack(ext_ack),
        .cs_n(cs_n), .int_ack(int_ack), .cyc_busy(cyc_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // Runs one bus cycle; ext_at / inject_at are cycle indices (-1 = never).
    task automatic run_cyc(input logic [31:0] a, input logic [2:0] sp, input logic xm,
                           input int ext_at, input int inject_at);
        @(negedge clk);
        cyc_start = 1'b1; cyc_addr = a; cyc_space = sp; cyc_ext_master = xm;
        @(negedge clk);
        cyc_start = 1'b0;
        r_ack = -1; r_len = 0; r_cs = cs_n; r_cs_ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            ext_ack = (k == ext_at);
            if (k == inject_at) begin
                cyc_start = 1'b1; cyc_addr = 32'h4012_0000; cyc_space = 3'd1;
            end else begin
                cyc_start = 1'b0;
            end
            #1;
            if (!cyc_busy) break;
            r_len++;
            if (cs_n !== r_cs) r_cs_ok = 1'b0;
            if (int_ack && r_ack < 0) r_ack = k;
            @(negedge clk);
        end
        r_idle_cs = cs_n;
        ext_ack = 1'b0; cyc_start = 1'b0;
    endtask

    task automatic expect_cyc(input string req, input logic [7:0] cs, input int ack, input int len);
        chk({req, " select"}, {24'b0, r_cs}, {24'b0, cs});
        chk({req, " int_ack cycle"}, ack, r_ack);
        chk({req, " cycle length"}, r_len, len);
        chk({req, " select held"}, {31'b0, r_cs_ok}, 32'd1);
        chk({req, " select released"}, {24'b0, r_idle_cs}, 32'h0000_00FF);
    endtask

    task automatic t_reset;
        chk("R1 cs_n", {24'b0, cs_n}, 32'h0000_00FF);
        chk("R1 busy", {31'b0, cyc_busy}, 32'd0);
        rd_chk("R1 ch0 ctrl", 5'd2, 32'h0000_003F);
        rd_chk("R1 ch0 mask", 5'd1, 32'h0);
        rd_chk("R1 ch1 ctrl", 5'd6, 32'h0);
        rd_chk("R1 ch7 base", 5'd28, 32'h0);
    endtask

    task automatic t_boot;
        run_cyc(32'h1234_5678, 3'd1, 1'b0, -1, -1);
        expect_cyc("R6 R7 boot 15 waits", 8'hFE, 15, 16);
    endtask

    task automatic t_regs;
        wr_reg(5'd4, 32'h4000_FFFF);
        rd_chk("R2 base reserved", 5'd4, 32'h4000_0000);
        wr_reg(5'd6, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl reserved", 5'd6, 32'h0000_7FFF);
        wr_reg(5'd7, 32'hFFFF_FFFF);
        rd_chk("R2 sel3 zero", 5'd7, 32'h0);
        wr_reg(5'd6, 32'h0000_0013);
        rd_chk("R2 ctrl readback", 5'd6, 32'h0000_0013);
        wr_reg(5'd1, 32'h0000_0001);
        rd_chk("R2 valid readback", 5'd1, 32'h0000_0001);
        wr_reg(5'd2, 32'h0000_0032);
    endtask

    task automatic t_valid_match;
        wr_reg(5'd5, 32'h00FF_0000);
        run_cyc(32'h4012_0000, 3'd1, 1'b0, 3, -1);
        expect_cyc("R5 R6 invalid region", 8'hFF, -1, 4);
        run_cyc(32'h0000_1234, 3'd1, 1'b0, -1, -1);
        expect_cyc("R6 ch0 as region", 8'hFE, 2, 3);
        wr_reg(5'd5, 32'h00FF_0001);
        run_cyc(32'h4012_0000, 3'd2, 1'b0, -1, -1);
        expect_cyc("R3 masked-bit match", 8'hFD, 3, 4);
        run_cyc(32'h4112_0000, 3'd2, 1'b0, 2, -1);
        expect_cyc("R3 compared-bit miss", 8'hFF, -1, 3);
    endtask

    task automatic t_priority;
        wr_reg(5'd8, 32'h4000_0000);
        wr_reg(5'd10, 32'h0000_0011);
        wr_reg(5'd9, 32'h0FFF_0001);
        run_cyc(32'h4012_0000, 3'd1, 1'b0, -1, -1);
        expect_cyc("R4 overlap lowest wins", 8'hFD, 3, 4);
        run_cyc(32'h4312_0000, 3'd1, 1'b0, -1, -1);
        expect_cyc("R4 only ch2", 8'hFB, 1, 2);
    endtask

    task automatic t_no_auto;
        wr_reg(5'd12, 32'h8000_0000);
        wr_reg(5'd14, 32'h0000_0000);
        wr_reg(5'd13, 32'h0000_0001);
        run_cyc(32'h8000_0010, 3'd2, 1'b0, 5, -1);
        expect_cyc("R8 auto off", 8'hF7, -1, 6);
    endtask

    task automatic t_ext_early;
        run_cyc(32'h4012_0000, 3'd1, 1'b0, 1, -1);
        expect_cyc("R9 ext ack mid-count", 8'hFD, -1, 2);
        run_cyc(32'h4012_0000, 3'd1, 1'b0, 0, -1);
        expect_cyc("R9 ext ack first cycle", 8'hFD, -1, 1);
    endtask

    task automatic t_space;
        wr_reg(5'd16, 32'h9000_0000);
        wr_reg(5'd18, 32'h0000_4010);
        wr_reg(5'd17, 32'h0000_0001);
        run_cyc(32'h9000_0000, 3'd4, 1'b0, 2, -1);
        expect_cyc("R10 blocked user data", 8'hFF, -1, 3);
        run_cyc(32'h9000_0000, 3'd3, 1'b0, -1, -1);
        expect_cyc("R10 open user code", 8'hEF, 0, 1);
    endtask

    task automatic t_ext_master;
        wr_reg(5'd20, 32'hA000_0000);
        wr_reg(5'd22, 32'h0000_4410);
        wr_reg(5'd21, 32'h0000_0001);
        run_cyc(32'hA000_0000, 3'd4, 1'b1, -1, -1);
        expect_cyc("R11 ext master waives data block", 8'hDF, 0, 1);
        run_cyc(32'hA000_0000, 3'd0, 1'b1, 1, -1);
        expect_cyc("R11 cpu block still applies", 8'hFF, -1, 2);
        run_cyc(32'hA000_0000, 3'd4, 1'b0, 1, -1);
        expect_cyc("R11 R10 local master blocked", 8'hFF, -1, 2);
    endtask

    task automatic t_busy_start;
        run_cyc(32'h8000_0010, 3'd2, 1'b0, 3, 1);
        expect_cyc("R12 start ignored while busy", 8'hF7, -1, 4);
        @(negedge clk);
        chk("R12 no second cycle", {31'b0, cyc_busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_boot();
        t_regs();
        t_valid_match();
        t_priority();
        t_no_auto();
        t_ext_early();
        t_space();
        t_ext_master();
        t_busy_start();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule